// File: doc/BRIEF.md
# DMA Request Pin Generator

This block drives one request line toward an external DMA controller. Software arms the request by writing a control word on a small register port. The word holds a trigger bit, a polarity bit and a mode bit. The output then takes its asserted level. The trigger bit stays set for as long as the request is outstanding, and it clears in the same cycle that the line returns to its idle level. Software can therefore poll the trigger bit to learn when the transfer request has been taken.

The mode bit selects how the request ends. In level mode the request is held until the host side performs an access with both its active-low select inputs low. Those two inputs arrive from another clock domain and pass through a synchronizer chain before they are used. In edge mode the host inputs are ignored, and the request is a pulse of a fixed number of peripheral clock cycles. The polarity bit sets which level counts as asserted. The idle level is always the opposite one, so a DMA controller that detects falling edges and one that detects rising edges can both be served.

Top module: `dreq_gen`

## Requirements
- R1: After reset the control word reads 0 (trigger bit 0, polarity bit 1, mode bit 2) and `dreq` is high.
- R2: When no request is active, a write with bit 0 set makes the trigger read 1 in the following cycle. From that cycle `dreq` equals the polarity bit.
- R3: A write with bit 0 clear leaves the trigger unchanged. A write with bit 0 set while a request is active is ignored and does not restart the edge-mode pulse.
- R4: Every write loads the polarity bit (bit 1) and the mode bit (bit 2). While no request is active, `dreq` shows the inverse of the polarity bit from the cycle after the write.
- R5: In level mode (bit 2 = 0), once `host_sel_n` and `host_reg_n` are both held low, the request negates SYNC_STAGES+1 cycles later. That is 3 cycles with the default two-stage synchronizer.
- R6: In edge mode (bit 2 = 1), `dreq` holds its asserted level for exactly PULSE_LEN cycles (default 32) and then negates.
- R7: The trigger bit reads 0 in the same cycle in which `dreq` returns to its idle level.
- R8: In level mode the request never times out while the host inputs are not both low. In edge mode the host inputs have no effect on the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | Control word: bit 0 trigger, bit 1 polarity, bit 2 mode |
| rd_data | output | 3 | Current control word, same bit layout as `wr_data` |
| host_sel_n | input | 1 | Host chip select, active low, asynchronous |
| host_reg_n | input | 1 | Host register select, active low, asynchronous |
| dreq | output | 1 | DMA request pin |

## Verification
The bench builds the block with PULSE_LEN = 8 and SYNC_STAGES = 2. The short pulse makes it cheap to count every asserted cycle of each edge-mode pulse, and the expected latency is computed from the parameters. Both polarities are swept against both modes, and all four host-input combinations are applied in level mode. Re-trigger writes and zero-trigger writes are placed inside active pulses, which exposes any restart of the counter or any early clear of the request.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  localparam int CTRL_W   = 3;
  localparam int TRIG_BIT = 0;
  localparam int POL_BIT  = 1;
  localparam int MODE_BIT = 2;

  // bit 2 mode, bit 1 polarity, bit 0 trigger
  typedef struct packed {
    logic mode;
    logic pol;
    logic trig;
  } dreq_ctrl_t;

  // Pin level for a given activity and polarity: asserted level equals pol.
  function automatic logic pin_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

  // Host access that satisfies a level request: both selects low.
  function automatic logic host_hit(input logic sel_n, input logic reg_n);
    return (!sel_n) && (!reg_n);
  endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/dreq_pulse_timer.sv
module dreq_pulse_timer #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  localparam int CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= '0;
    else if (run && !done)  cnt <= cnt + CW'(1);
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));

endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              clear_evt,
  output dreq_ctrl_t        ctrl,
  output logic              set_evt
);

  assign set_evt = wr_en && wr_data[TRIG_BIT] && !ctrl.trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_en) begin
        ctrl.pol  <= wr_data[POL_BIT];
        ctrl.mode <= wr_data[MODE_BIT];
      end
      if (set_evt)        ctrl.trig <= 1'b1;
      else if (clear_evt) ctrl.trig <= 1'b0;
    end
  end

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.trig && wr_en && wr_data[TRIG_BIT]) |=> ctrl.trig);

  // R3
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.trig && !(wr_en && wr_data[TRIG_BIT])) |=> !ctrl.trig);

  // R3
  rearm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.trig && !clear_evt) |=> ctrl.trig);

  // R4
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl.pol == $past(wr_data[POL_BIT]) && ctrl.mode == $past(wr_data[MODE_BIT])));

endmodule

// File: rtl/dreq_gen.sv
module dreq_gen
  import dreq_pkg::*;
#(
  parameter int PULSE_LEN   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              host_sel_n,
  input  logic              host_reg_n,
  output logic              dreq
);

  dreq_ctrl_t ctrl;
  logic       set_evt;
  logic       clear_evt;
  logic       pulse_done;
  logic       hit_sync;
  logic [1:0] host_sync;

  dreq_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({host_sel_n, host_reg_n}),
    .q_sync  (host_sync)
  );

  assign hit_sync = host_hit(host_sync[1], host_sync[0]);

  dreq_pulse_timer #(
    .PULSE_LEN (PULSE_LEN)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (set_evt),
    .run   (ctrl.trig && ctrl.mode),
    .done  (pulse_done)
  );

  assign clear_evt = ctrl.trig && (ctrl.mode ? pulse_done : hit_sync);

  dreq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .clear_evt (clear_evt),
    .ctrl      (ctrl),
    .set_evt   (set_evt)
  );

  assign dreq    = pin_level(ctrl.trig, ctrl.pol);
  assign rd_data = ctrl;

  // R5
  level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.trig && !ctrl.mode && hit_sync && !(wr_en && wr_data[MODE_BIT])) |=> !ctrl.trig);

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.trig && ctrl.mode && pulse_done) |=> !ctrl.trig);

  // R8
  edge_host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.trig && ctrl.mode && !pulse_done) |=> ctrl.trig);

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.trig) |-> (dreq == !ctrl.pol));

endmodule

// File: tb/sim_dreq_gen.sv
module sim_dreq_gen;

  localparam int PLEN = 8;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'b000;
  logic [2:0] rd_data;
  logic       host_sel_n = 1'b1;
  logic       host_reg_n = 1'b1;
  logic       dreq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dreq_gen #(.PULSE_LEN(PLEN), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .host_sel_n(host_sel_n), .host_reg_n(host_reg_n),
    .dreq(dreq)
  );

  function automatic logic [2:0] word(input logic m, input logic p, input logic t);
    return {m, p, t};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count asserted cycles; already aligned on the negedge following arming
  task automatic measure(input logic pol, input logic m, input int rearm_at,
                         input bit zero_write, output int n, output bit trig_ok);
    n = 0;
    trig_ok = 1'b1;
    while (dreq == pol && n < 1000) begin
      if (rd_data[0] != 1'b1) trig_ok = 1'b0;
      n++;
      if (n == rearm_at) begin
        wr_en = 1'b1;
        wr_data = zero_write ? word(m, pol, 1'b0) : word(m, pol, 1'b1);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (rd_data[0] != 1'b0) trig_ok = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit tok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 3'b000, "R1 ctrl", rd_data, 0);
    chk(dreq == 1'b1, "R1 dreq", dreq, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 2; p++) begin
      logic pol;
      pol = logic'(p);
      // R4 idle level follows polarity
      wr(word(1'b0, pol, 1'b0));
      chk(dreq == !pol, "R4 idle", dreq, !pol);
      chk(rd_data == word(1'b0, pol, 1'b0), "R4 readback", rd_data, word(1'b0, pol, 1'b0));
      // R3 zero write leaves trigger clear
      wr(word(1'b0, pol, 1'b0));
      chk(rd_data[0] == 1'b0, "R3 zero write idle", rd_data[0], 0);

      // level mode: R2 arm
      wr(word(1'b0, pol, 1'b1));
      chk(dreq == pol, "R2 level arm", dreq, pol);
      chk(rd_data[0] == 1'b1, "R2 trigger", rd_data[0], 1);
      // R8 non-qualifying host inputs, no timeout
      for (int c = 0; c < 3; c++) begin
        host_sel_n = (c == 0 || c == 2);
        host_reg_n = (c == 0 || c == 1);
        repeat (PLEN + 5) @(negedge clk);
        chk(dreq == pol, "R8 level holds", dreq, pol);
      end
      // R3 zero write during request
      wr(word(1'b0, pol, 1'b0));
      chk(rd_data[0] == 1'b1, "R3 zero write active", rd_data[0], 1);
      // R5 latency
      host_sel_n = 1'b0;
      host_reg_n = 1'b0;
      n = 0;
      @(negedge clk);
      n = 1;
      while (dreq == pol && n < 50) begin
        @(negedge clk);
        n++;
      end
      chk(n == LAT, "R5 latency", n, LAT);
      // R7 trigger clears with negation
      chk(rd_data[0] == 1'b0, "R7 level clear", rd_data[0], 0);
      chk(dreq == !pol, "R7 level idle", dreq, !pol);
      host_sel_n = 1'b1;
      host_reg_n = 1'b1;
      repeat (LAT + 1) @(negedge clk);

      // edge mode: R6 plain, R3 rearm, R3 zero write, R8 host active
      for (int v = 0; v < 4; v++) begin
        if (v == 3) begin
          host_sel_n = 1'b0;
          host_reg_n = 1'b0;
        end
        wr(word(1'b1, pol, 1'b1));
        chk(dreq == pol, "R2 edge arm", dreq, pol);
        measure(pol, 1'b1, (v == 1 || v == 2) ? 3 : 0, v == 2, n, tok);
        if (v == 0) chk(n == PLEN, "R6 pulse length", n, PLEN);
        if (v == 1) chk(n == PLEN, "R3 rearm ignored", n, PLEN);
        if (v == 2) chk(n == PLEN, "R3 zero write in pulse", n, PLEN);
        if (v == 3) chk(n == PLEN, "R8 edge ignores host", n, PLEN);
        chk(tok, "R7 edge trigger tracks pin", tok, 1);
        host_sel_n = 1'b1;
        host_reg_n = 1'b1;
        repeat (LAT + 1) @(negedge clk);
      end
      // R4 polarity flip while idle
      wr(word(1'b1, !pol, 1'b0));
      chk(dreq == pol, "R4 flip", dreq, pol);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule